// File: doc/BRIEF.md
# Debounced Edge Trigger Interrupt Controller

This block sits between a small set of key inputs and a playback sequencer. Each key pin is active low: an idle pin reads high through a pull-up, a press drives it low and a release lets it return high. Every pin is brought into the clock domain through two flops and then filtered by a stability counter. A new level is accepted only after the synchronized input has held that value for the whole debounce window. One of two window lengths, both given in clock cycles, is chosen at run time by a select input.

Each accepted transition is a press (falling) event or a release (rising) event. Each of these events has its own bit in an 8-bit enable word. A press of pin p uses bit p, and a release of pin p uses bit NPINS+p. When the enable bit is set, the event raises a one-cycle request. The request carries a 3-bit vector equal to that bit index, and the sequencer uses the vector as the entry number of the routine to run. The last pin can be reassigned as an output, and while it is, its transitions never raise a request. The filtered levels of all pins are also exported so that conditional instructions can test them.

Top module: `trig_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0 and `lvl_o` reads all ones (all keys released).
- R2: A press (high to low) of pin p is accepted when the synchronized input has stayed low for L consecutive cycles. If enable bit p is set, `irq_o` is then high for exactly one cycle with `irq_vec_o` = p. A pin change applied just after clock edge c is seen on `irq_o` after clock edge c+2+L.
- R3: A release (low to high) of pin p is accepted the same way. If enable bit NPINS+p is set, it gives a one-cycle request with `irq_vec_o` = NPINS+p. With four pins, releasing pin 3 (the third, index 2) gives vector 6.
- R4: An accepted edge whose enable bit is 0 raises no request, but `lvl_o` still follows the accepted level.
- R5: A change that lasts fewer than L cycles is ignored: `lvl_o` and `irq_o` do not move. `lvl_o[p]` gives the accepted level of pin p, with 1 meaning released, and it changes in the same cycle as the request.
- R6: When `deb_long_i` is 1, L is DEB_LONG_CYC. When it is 0, L is DEB_SHORT_CYC.
- R7: When `pin4_is_trig_i` is 0, no transition of pin NPINS-1 raises a request, neither a press (vector NPINS-1) nor a release (vector 2*NPINS-1).
- R8: If several enabled edges are accepted in the same cycle, one single-cycle request is raised and it carries the lowest enable bit index among them. The other edges are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_n_i | input | NPINS (4) | Raw key pins, low when pressed |
| edge_en_i | input | 2*NPINS (8) | Enable word: bit p is the press of pin p, bit NPINS+p is its release |
| deb_long_i | input | 1 | 1 selects the long debounce window, 0 the short one |
| pin4_is_trig_i | input | 1 | 1 keeps the last pin as a trigger, 0 gives it over to output use |
| irq_o | output | 1 | One-cycle interrupt request |
| irq_vec_o | output | $clog2(2*NPINS) (3) | Vector of the request |
| lvl_o | output | NPINS (4) | Debounced pin levels, 1 means released |

## Verification
Two pins can complete their debounce windows on the same clock edge. Only one request can leave the block in that cycle, so the event arbitration is the point where two functions meet. The bench provokes this by pressing two pins on the same falling clock edge, and later by releasing both together. The scoreboard expects exactly one request, at the computed cycle, carrying the lower index. Any second request counts as an unexpected item, and the levels of both pins must still update.

// File: rtl/trig_irq_pkg.sv
package trig_irq_pkg;

  // accepted transitions of one debounced pin
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_pair_t;

  // debounce window in cycles for the chosen setting
  function automatic int unsigned deb_window(input logic use_long,
                                             input int unsigned long_cyc,
                                             input int unsigned short_cyc);
    return use_long ? long_cyc : short_cyc;
  endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= d_i;
      s2 <= s1;
    end
  end

  assign q_o = s2;
endmodule

// File: rtl/trig_debounce.sv
module trig_debounce #(
  parameter int CW = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   din_i,
  input  logic [CW-1:0]          lim_i,
  output logic                   lvl_o,
  output trig_irq_pkg::edge_pair_t ev_o
);
  logic [CW-1:0] cnt;
  logic          differ;
  logic          accept;

  assign differ = din_i != lvl_o;
  // accept on the cycle the input has differed for the full window
  assign accept = differ && (cnt >= lim_i - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      lvl_o <= 1'b1;
    end else if (accept) begin
      cnt   <= '0;
      lvl_o <= din_i;
    end else if (differ) begin
      cnt   <= cnt + CW'(1);
    end else begin
      cnt   <= '0;
    end
  end

  assign ev_o.rise = accept && din_i;
  assign ev_o.fall = accept && !din_i;
endmodule

// File: rtl/trig_prio.sv
module trig_prio #(
  parameter int N = 8,
  localparam int VW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [VW-1:0] idx_o
);
  function automatic logic [VW-1:0] lowest_set(input logic [N-1:0] v);
    logic [VW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = VW'(i);
    end
    return r;
  endfunction

  assign any_o = |req_i;
  assign idx_o = lowest_set(req_i);
endmodule

// File: rtl/trig_irq_ctrl.sv
module trig_irq_ctrl #(
  parameter int NPINS         = 4,
  parameter int DEB_LONG_CYC  = 40,
  parameter int DEB_SHORT_CYC = 5,
  localparam int NEDGE = 2 * NPINS,
  localparam int VW    = $clog2(NEDGE),
  localparam int CW    = $clog2(DEB_LONG_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_n_i,
  input  logic [NEDGE-1:0] edge_en_i,
  input  logic             deb_long_i,
  input  logic             pin4_is_trig_i,
  output logic             irq_o,
  output logic [VW-1:0]    irq_vec_o,
  output logic [NPINS-1:0] lvl_o
);
  import trig_irq_pkg::*;

  logic [CW-1:0]    lim;
  logic [NPINS-1:0] pin_sync;
  edge_pair_t       ev [NPINS];
  logic [NEDGE-1:0] edge_raw;
  logic [NEDGE-1:0] pin_keep;
  logic [NEDGE-1:0] edge_hit;   // enabled, accepted edges this cycle
  logic             hit_any;
  logic [VW-1:0]    hit_idx;

  assign lim = CW'(deb_window(deb_long_i, DEB_LONG_CYC, DEB_SHORT_CYC));

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    trig_sync u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_n_i[p]),
      .q_o   (pin_sync[p])
    );

    trig_debounce #(.CW(CW)) u_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .din_i (pin_sync[p]),
      .lim_i (lim),
      .lvl_o (lvl_o[p]),
      .ev_o  (ev[p])
    );

    assign edge_raw[p]         = ev[p].fall;
    assign edge_raw[NPINS + p] = ev[p].rise;

    if (p == NPINS - 1) begin : g_shared
      assign pin_keep[p]         = pin4_is_trig_i;
      assign pin_keep[NPINS + p] = pin4_is_trig_i;
    end else begin : g_plain
      assign pin_keep[p]         = 1'b1;
      assign pin_keep[NPINS + p] = 1'b1;
    end
  end

  assign edge_hit = edge_raw & edge_en_i & pin_keep;

  trig_prio #(.N(NEDGE)) u_prio (
    .req_i (edge_hit),
    .any_o (hit_any),
    .idx_o (hit_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o     <= 1'b0;
      irq_vec_o <= '0;
    end else begin
      irq_o     <= hit_any;
      if (hit_any) irq_vec_o <= hit_idx;
    end
  end
endmodule

// File: rtl/trig_irq_chk.sv
module trig_irq_chk #(
  parameter int NPINS = 4,
  localparam int NEDGE = 2 * NPINS,
  localparam int VW    = $clog2(NEDGE)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NEDGE-1:0] edge_en_i,
  input logic             pin4_is_trig_i,
  input logic [NEDGE-1:0] edge_hit,
  input logic             irq_o,
  input logic [VW-1:0]    irq_vec_o,
  input logic [NPINS-1:0] lvl_o
);
  logic          is_rise;
  logic [VW-1:0] pidx;
  logic [NPINS-1:0] lvl_sh;

  assign is_rise = irq_vec_o >= VW'(NPINS);
  assign pidx    = is_rise ? irq_vec_o - VW'(NPINS) : irq_vec_o;
  assign lvl_sh  = lvl_o >> pidx;

  assert_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((($past(edge_en_i) >> irq_vec_o) & NEDGE'(1)) != '0));

  assert_fall_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !is_rise) |-> (!lvl_sh[0] && ((($past(lvl_o) >> pidx) & NPINS'(1)) != '0)));

  assert_rise_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && is_rise) |-> (lvl_sh[0] && ((($past(lvl_o) >> pidx) & NPINS'(1)) == '0)));

  assert_pin4_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !$past(pin4_is_trig_i)) |-> (pidx != VW'(NPINS - 1)));

  assert_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (($past(edge_hit) & ((NEDGE'(1) << irq_vec_o) - NEDGE'(1))) == '0));

  assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(edge_hit) == '0) |-> !irq_o);
endmodule

bind trig_irq_ctrl trig_irq_chk #(.NPINS(NPINS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .edge_en_i      (edge_en_i),
  .pin4_is_trig_i (pin4_is_trig_i),
  .edge_hit       (edge_hit),
  .irq_o          (irq_o),
  .irq_vec_o      (irq_vec_o),
  .lvl_o          (lvl_o)
);

// File: tb/sim_trig_irq_ctrl.sv
module sim_trig_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP   = 4;
  localparam int LONG = 40;
  localparam int SHRT = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pin_n = 4'hF;
  logic [7:0] en = 8'hFF;
  logic       deb_long = 1'b1;
  logic       pin4_trig = 1'b1;
  logic       irq_o;
  logic [2:0] irq_vec_o;
  logic [3:0] lvl_o;

  trig_irq_ctrl #(.NPINS(NP), .DEB_LONG_CYC(LONG), .DEB_SHORT_CYC(SHRT)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_n_i(pin_n), .edge_en_i(en),
    .deb_long_i(deb_long), .pin4_is_trig_i(pin4_trig),
    .irq_o(irq_o), .irq_vec_o(irq_vec_o), .lvl_o(lvl_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    logic [2:0] vec;
    int         cyc;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop the scoreboard on every request
  always @(negedge clk) begin
    if (rst_n && irq_o) begin
      if (q.size() == 0) begin
        chk(1'b0, "unexpected request (R4/R7/R8)", int'(irq_vec_o), 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(irq_vec_o == e.vec, {e.tag, " vector"}, int'(irq_vec_o), int'(e.vec));
        chk(cyc == e.cyc, {e.tag, " cycle"}, cyc, e.cyc);
      end
    end
  end

  task automatic drive(input logic [3:0] p, input bit expect_irq,
                       input logic [2:0] vec, input string tag);
    exp_t e;
    @(negedge clk);
    pin_n = p;
    if (expect_irq) begin
      e.vec = vec;
      e.cyc = cyc + 2 + (deb_long ? LONG : SHRT);
      e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic settle(input string tag);
    repeat (LONG + 8) @(negedge clk);
    chk(q.size() == 0, {tag, " pending"}, q.size(), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_o == 1'b0, "R1 irq", int'(irq_o), 0);
    chk(lvl_o == 4'hF, "R1 lvl", int'(lvl_o), 15);

    // press and release pin 0
    drive(4'b1110, 1'b1, 3'd0, "R2 press pin0");
    settle("R2");
    chk(lvl_o == 4'hE, "R5 lvl after press", int'(lvl_o), 14);
    drive(4'b1111, 1'b1, 3'd4, "R3 release pin0");
    settle("R3");

    // pin 2: press gives 2, release gives 6
    drive(4'b1011, 1'b1, 3'd2, "R2 press pin2");
    settle("R2 pin2");
    drive(4'b1111, 1'b1, 3'd6, "R3 release pin2");
    settle("R3 pin2");

    // masked edges on pin 1
    en = 8'h41;
    drive(4'b1101, 1'b0, 3'd0, "");
    settle("R4 press");
    chk(lvl_o == 4'hD, "R4 lvl masked press", int'(lvl_o), 13);
    drive(4'b1111, 1'b0, 3'd0, "");
    settle("R4 release");
    chk(lvl_o == 4'hF, "R4 lvl masked release", int'(lvl_o), 15);
    en = 8'hFF;

    // short glitch is filtered
    @(negedge clk);
    pin_n = 4'b1110;
    repeat (10) @(negedge clk);
    pin_n = 4'b1111;
    settle("R5 glitch");
    chk(lvl_o == 4'hF, "R5 lvl after glitch", int'(lvl_o), 15);

    // short window
    deb_long = 1'b0;
    drive(4'b0111, 1'b1, 3'd3, "R6 short press pin3");
    settle("R6");
    drive(4'b1111, 1'b1, 3'd7, "R6 short release pin3");
    settle("R6 rel");
    deb_long = 1'b1;

    // last pin used as output
    pin4_trig = 1'b0;
    drive(4'b0111, 1'b0, 3'd0, "");
    settle("R7 press");
    drive(4'b1111, 1'b0, 3'd0, "");
    settle("R7 release");
    pin4_trig = 1'b1;

    // simultaneous edges on pins 1 and 2
    drive(4'b1001, 1'b1, 3'd1, "R8 press pins1+2");
    settle("R8");
    chk(lvl_o == 4'h9, "R8 lvl both pressed", int'(lvl_o), 9);
    drive(4'b1111, 1'b1, 3'd5, "R8 release pins1+2");
    settle("R8 rel");
    chk(lvl_o == 4'hF, "R8 lvl both released", int'(lvl_o), 15);

    finish_run();
  end
endmodule